// File: doc/BRIEF.md
# Per-pin interrupt sense and latch

This block turns a vector of external pin levels into per-pin interrupt status and one merged interrupt request. Every pin has its own trigger setup made of three independent bits: an inversion bit, an edge-or-level bit and a dual-edge bit. A fourth bit, the mode bit, decides whether the pin acts as an interrupt input at all. Pins first cross into the clock domain through a synchronizer. Edges are found by comparing the newest synchronized sample with the one taken a cycle earlier.

Level-triggered pins give a status bit that simply tracks the corrected pin level. Edge-triggered pins latch their status bit. It stays set until software pulses that pin's clear line. The merged request is raised while any status bit is set whose enable bit is also set. Register decode and glitch filtering sit outside the block. The block takes plain vectors and single-cycle clear pulses.

Top module: `irq_sense_latch`

## Requirements
- R1: A change on `pin_in` driven before clock edge k first shows in `status` after edge k+2. With `SYNC_STAGES`=2 that is one synchronizer edge, one sample edge and one latch edge.
- R2: The inversion bit selects the active sense. `polarity[i]`=0 means a high level or a rising edge. `polarity[i]`=1 means a low level or a falling edge.
- R3: `edge_sel[i]`=0 makes pin i level-triggered. Its status equals the synchronized level XOR `polarity[i]`, updated every cycle.
- R4: With `edge_sel[i]`=1 and `both_edge[i]`=1, a rise and a fall both set the status, whatever `polarity[i]` holds. With `both_edge[i]`=0, only the edge chosen by R2 sets it.
- R5: A pin with `irq_mode[i]`=0 (general I/O) always has status 0, whatever its pin does.
- R6: An edge-latched status bit stays set, whatever the pin does, until `clr_pulse[i]`=1 is sampled at a clock edge. That clock edge clears the bit.
- R7: On a level-triggered pin, `clr_pulse[i]` has no lasting effect: the status bit keeps following the level.
- R8: If a new edge and a clear for the same pin meet at the same clock edge, the edge wins and the status stays set.
- R9: Changing a pin's configuration bits does not by itself set an edge status. The previous-sample register keeps tracking the pin while it is in general I/O mode, so switching to interrupt mode after the pin has moved creates no edge.
- R10: `irq_req` is 1 exactly when some bit is set in both `status` and `irq_enable` (enable bit 1 = unmasked). It follows `status` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| irq_mode | input | NUM_PINS | 1 = pin is an interrupt input, 0 = general I/O |
| polarity | input | NUM_PINS | 0 = high/rising, 1 = low/falling |
| edge_sel | input | NUM_PINS | 1 = edge-triggered, 0 = level-triggered |
| both_edge | input | NUM_PINS | 1 = either transition triggers (edge pins only) |
| clr_pulse | input | NUM_PINS | Write-one clear of edge-latched status |
| irq_enable | input | NUM_PINS | Per-pin request enable, 1 = unmasked |
| status | output | NUM_PINS | Per-pin interrupt status |
| irq_req | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with `NUM_PINS`=4 and the default two-stage synchronizer. The narrow vector makes a full sweep affordable: every pin is driven through every combination of mode, inversion, edge and dual-edge bits. Each combination sees all four start and end levels, and the other pins act as quiet neighbours that must stay zero. Directed sequences then cover the exact latency, a clear landing on the same edge as a new transition, a clear on a level pin, and reconfiguration of a pin whose level moved while it was in general I/O mode.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    // How one pin decides that it is asserting.
    typedef enum logic [1:0] {
        TRIG_OFF      = 2'd0,
        TRIG_LEVEL    = 2'd1,
        TRIG_ONE_EDGE = 2'd2,
        TRIG_ANY_EDGE = 2'd3
    } trig_kind_e;

    // Configuration bits of one pin, gathered from the flat port vectors.
    typedef struct packed {
        logic active;
        logic invert;
        logic edge_mode;
        logic dual;
    } pin_cfg_t;

    // Per-pin result of the trigger evaluation, handed to the latch.
    typedef struct packed {
        trig_kind_e kind;
        logic       hit;
        logic       level;
    } pin_eval_t;

    function automatic trig_kind_e classify(pin_cfg_t c);
        trig_kind_e k;
        if (!c.active)         k = TRIG_OFF;
        else if (!c.edge_mode) k = TRIG_LEVEL;
        else if (c.dual)       k = TRIG_ANY_EDGE;
        else                   k = TRIG_ONE_EDGE;
        return k;
    endfunction

    // Transition detector: old and new synchronized samples of one pin.
    function automatic logic edge_hit(trig_kind_e k, logic invert,
                                      logic prev, logic cur);
        logic r;
        case (k)
            TRIG_ANY_EDGE: r = prev ^ cur;
            TRIG_ONE_EDGE: r = invert ? (prev & ~cur) : (~prev & cur);
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_cur,
    output logic [NUM_PINS-1:0] pin_old
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
    logic [NUM_PINS-1:0] old_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // Tracks every pin regardless of mode, so reconfiguration sees no stale edge.
    always_ff @(posedge clk) begin
        if (rst) old_q <= '0;
        else     old_q <= stage_q[LAST];
    end

    assign pin_cur = stage_q[LAST];
    assign pin_old = old_q;
endmodule

// File: rtl/irq_trigger_eval.sv
module irq_trigger_eval
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] pin_cur,
    input  logic [NUM_PINS-1:0] pin_old,
    input  logic [NUM_PINS-1:0] irq_mode,
    input  logic [NUM_PINS-1:0] polarity,
    input  logic [NUM_PINS-1:0] edge_sel,
    input  logic [NUM_PINS-1:0] both_edge,
    output pin_eval_t [NUM_PINS-1:0] eval
);
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            pin_cfg_t   cfg;
            trig_kind_e kind;

            always_comb begin
                cfg.active    = irq_mode[i];
                cfg.invert    = polarity[i];
                cfg.edge_mode = edge_sel[i];
                cfg.dual      = both_edge[i];
                kind          = classify(cfg);
                eval[i].kind  = kind;
                eval[i].hit   = edge_hit(kind, cfg.invert, pin_old[i], pin_cur[i]);
                eval[i].level = pin_cur[i] ^ cfg.invert;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pin_eval_t [NUM_PINS-1:0] eval,
    input  logic [NUM_PINS-1:0]      clr_pulse,
    output logic [NUM_PINS-1:0]      status
);
    logic [NUM_PINS-1:0] stat_q;
    logic [NUM_PINS-1:0] stat_d;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
            always_comb begin
                case (eval[i].kind)
                    TRIG_OFF:   stat_d[i] = 1'b0;
                    TRIG_LEVEL: stat_d[i] = eval[i].level;
                    // A fresh edge outranks a clear arriving at the same edge.
                    default:    stat_d[i] = eval[i].hit | (stat_q[i] & ~clr_pulse[i]);
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign status = stat_q;
endmodule

// File: rtl/irq_request_merge.sv
module irq_request_merge #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] status,
    input  logic [NUM_PINS-1:0] irq_enable,
    output logic                irq_req
);
    logic [NUM_PINS-1:0] pending;

    always_comb begin
        pending = status & irq_enable;
        irq_req = |pending;
    end
endmodule

// File: rtl/irq_sense_latch.sv
module irq_sense_latch
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] irq_mode,
    input  logic [NUM_PINS-1:0] polarity,
    input  logic [NUM_PINS-1:0] edge_sel,
    input  logic [NUM_PINS-1:0] both_edge,
    input  logic [NUM_PINS-1:0] clr_pulse,
    input  logic [NUM_PINS-1:0] irq_enable,
    output logic [NUM_PINS-1:0] status,
    output logic                irq_req
);
    logic [NUM_PINS-1:0]      pin_sync;
    logic [NUM_PINS-1:0]      pin_prev;
    pin_eval_t [NUM_PINS-1:0] pin_eval;

    irq_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_in),
        .pin_cur (pin_sync),
        .pin_old (pin_prev)
    );

    irq_trigger_eval #(.NUM_PINS(NUM_PINS)) u_eval (
        .pin_cur   (pin_sync),
        .pin_old   (pin_prev),
        .irq_mode  (irq_mode),
        .polarity  (polarity),
        .edge_sel  (edge_sel),
        .both_edge (both_edge),
        .eval      (pin_eval)
    );

    irq_status_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .eval      (pin_eval),
        .clr_pulse (clr_pulse),
        .status    (status)
    );

    irq_request_merge #(.NUM_PINS(NUM_PINS)) u_merge (
        .status     (status),
        .irq_enable (irq_enable),
        .irq_req    (irq_req)
    );
endmodule

// File: rtl/irq_sense_latch_chk.sv
module irq_sense_latch_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] irq_mode,
    input logic [NUM_PINS-1:0] polarity,
    input logic [NUM_PINS-1:0] edge_sel,
    input logic [NUM_PINS-1:0] clr_pulse,
    input logic [NUM_PINS-1:0] irq_enable,
    input logic [NUM_PINS-1:0] pin_sync,
    input logic [NUM_PINS-1:0] pin_prev,
    input logic [NUM_PINS-1:0] status,
    input logic                irq_req
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R10: no request without a set status bit, none while all enables are low
    a_r10_req_needs_status: assert property (@(posedge clk) disable iff (rst)
        ($countones(status) == 0) |-> !irq_req);
    a_r10_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_enable == '0) |-> !irq_req);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            // R5: general I/O pins never hold status
            a_r5_io_pin_quiet: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(!irq_mode[i])) |-> !status[i]);
            // R6: edge status is kept while no clear arrives
            a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(irq_mode[i] && edge_sel[i] && status[i] && !clr_pulse[i]))
                |-> status[i]);
            // R3: level pins follow the corrected synchronized level
            a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(irq_mode[i] && !edge_sel[i]))
                |-> (status[i] == $past(pin_sync[i] ^ polarity[i])));
            // R9: without a sample change an edge pin cannot become set
            a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(irq_mode[i] && edge_sel[i] && !status[i]
                               && (pin_sync[i] == pin_prev[i]))) |-> !status[i]);
        end
    endgenerate
endmodule

bind irq_sense_latch irq_sense_latch_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_mode   (irq_mode),
    .polarity   (polarity),
    .edge_sel   (edge_sel),
    .clr_pulse  (clr_pulse),
    .irq_enable (irq_enable),
    .pin_sync   (pin_sync),
    .pin_prev   (pin_prev),
    .status     (status),
    .irq_req    (irq_req)
);

// File: tb/irq_sense_latch_test.sv
module irq_sense_latch_test;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_in, irq_mode, polarity, edge_sel, both_edge, clr_pulse, irq_enable;
    logic [NP-1:0] status;
    logic          irq_req;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    irq_sense_latch #(.NUM_PINS(NP), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .irq_mode(irq_mode),
        .polarity(polarity), .edge_sel(edge_sel), .both_edge(both_edge),
        .clr_pulse(clr_pulse), .irq_enable(irq_enable),
        .status(status), .irq_req(irq_req)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear(logic [NP-1:0] m);
        clr_pulse = m;
        tick(1);
        clr_pulse = '0;
    endtask

    // One sweep point: pin p, given setup, level a then b.
    task automatic run_case(int p, bit md, bit pol, bit edg, bit both, bit a, bit b, bit en);
        logic [NP-1:0] one;
        bit hit, exp0, exp1;
        one = NP'(1) << p;
        irq_mode = '0; polarity = '0; edge_sel = '0; both_edge = '0;
        pin_in[p] = a;
        tick(4);
        irq_mode[p] = md; polarity[p] = pol; edge_sel[p] = edg; both_edge[p] = both;
        irq_enable = en ? one : ~one;
        tick(3);
        pulse_clear(one);
        tick(2);
        exp0 = md && !edg && (a ^ pol);
        check(edg ? "R9 no status from setup" : "R3 level before", status, exp0 ? one : '0);
        pin_in[p] = b;
        tick(3);
        hit = both ? (a != b) : (pol ? (a && !b) : (!a && b));
        exp1 = md && (edg ? hit : (b ^ pol));
        if (!md)            check("R5 io pin quiet", status, '0);
        else if (!edg)      check("R2/R3 level after", status, exp1 ? one : '0);
        else if (both)      check("R4 dual edge", status, exp1 ? one : '0);
        else                check("R2 single edge", status, exp1 ? one : '0);
        check("R10 request", irq_req, exp1 && en);
        if (md && edg && hit) begin
            pin_in[p] = a;
            tick(5);
            check("R6 sticky", status, one);
            pulse_clear(one);
            check("R6 cleared", status, '0);
        end
    endtask

    initial begin
        rst = 1'b1;
        pin_in = '0; irq_mode = '0; polarity = '0; edge_sel = '0;
        both_edge = '0; clr_pulse = '0; irq_enable = '1;
        tick(3);
        check("reset status", status, '0);
        check("reset request", irq_req, 0);
        rst = 1'b0;
        tick(2);

        for (int p = 0; p < NP; p++)
            for (int c = 0; c < 64; c++)
                run_case(p, c[5], c[4], c[3], c[2], c[1], c[0], c[0] ^ c[2]);

        // R1: latency of a rising level on pin 2
        irq_mode = 4'b0100; polarity = '0; edge_sel = '0; both_edge = '0;
        pin_in = '0; irq_enable = '1;
        tick(4);
        pin_in[2] = 1'b1;
        tick(2);
        check("R1 not yet after two edges", status, '0);
        tick(1);
        check("R1 visible after third edge", status, 4'b0100);

        // R7: clear on a level pin has no lasting effect
        pulse_clear(4'b0100);
        check("R7 level survives clear", status, 4'b0100);
        tick(1);
        check("R7 level still set", status, 4'b0100);

        // R8: new edge and clear meet at the same edge
        pin_in = '0; irq_mode = 4'b0010; edge_sel = 4'b0010; both_edge = 4'b0010;
        tick(4);
        pulse_clear(4'b0010);
        pin_in[1] = 1'b1;
        tick(3);
        check("R8 first edge sets", status, 4'b0010);
        pin_in[1] = 1'b0;
        tick(2);
        clr_pulse = 4'b0010;
        tick(1);
        clr_pulse = '0;
        check("R8 edge beats clear", status, 4'b0010);
        pulse_clear(4'b0010);
        check("R8 plain clear", status, '0);

        // R9: pin moves while in general I/O, then becomes a rising-edge pin
        irq_mode = '0; edge_sel = 4'b1000; both_edge = '0; polarity = '0;
        pin_in = 4'b1000;
        tick(5);
        irq_mode = 4'b1000;
        tick(3);
        check("R9 mode switch no edge", status, '0);
        polarity = 4'b1000; both_edge = 4'b1000;
        tick(3);
        check("R9 reconfig no edge", status, '0);
        edge_sel = '0;
        tick(1);
        edge_sel = 4'b1000;
        tick(3);
        check("R9 level detour no new edge", status, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R1 got=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule